// File: doc/BRIEF.md
# Master Serial Audio Port with Early-Sync Detection

This block is the master end of a two-slot serial audio link. It divides a fast reference clock (typically 256 times the sample rate) down to a bit clock and drives a frame sync whose period and high time are set by configuration. The frame-sync rise starts slot A and the fall starts slot B. Each slot carries one word, most significant bit first, one bit clock after the sync edge that opens it. The port shifts transmit words out on the falling bit-clock edge and samples receive data and receive sync on the rising edge. The same period and width settings serve both directions.

The receiver watches its sync input on its own. A sync rise that comes before a whole programmed frame has passed since the last one sets a sticky error flag. The partly received word is dropped and reception restarts from the new sync. In loopback mode the receiver takes the port's own outgoing sync and data in place of the pins, which splits board faults from logic faults.

Transmit words enter through a valid/ready handshake. `tx_ready` pulses for one clock each time a slot is about to start. A word offered with `tx_valid` is taken only in that cycle and must be held until then. If `tx_valid` is low in that cycle, the slot carries zeros; the port never waits. Received words leave on a one-clock `rx_valid` strobe with no back-pressure, because bit timing cannot stall.

Top module: `sap_master`

## Requirements
- R1: `sclk_o` toggles every `cfg_half`+1 reference clocks, so `cfg_half`=3 divides the reference by 8.
- R2: `fs_o` repeats every `cfg_per`+1 bit clocks and is high for the first `cfg_wid`+1 of them, with `cfg_wid` < `cfg_per`. With 16-bit words, 31/15 gives a 32-bit frame whose sync is high for 16 bits.
- R3: Reset is synchronous and active low, and leaves `sclk_o`, `fs_o`, `sd_o`, `tx_ready`, `rx_valid` and `err_o` low. The first `fs_o` rise comes one full frame after reset, which is 256 reference clocks with the defaults.
- R4: `fs_o` and `sd_o` change only as `sclk_o` falls. Each word goes out MSB first, starting one bit clock after the sync edge that opens its slot: rise for slot A, fall for slot B. `tx_ready` is high in the one clock that precedes that bit.
- R5: The receiver samples sync and data as `sclk_o` rises and uses the same slot framing as the transmitter. After the last bit of a slot, `rx_data` carries the word and `rx_valid` is high for exactly one clock. `rx_slot` is 0 for slot A and 1 for slot B.
- R6: With `cfg_loop`=1 the receiver uses `fs_o` and `sd_o` as its inputs and ignores `fs_i` and `sd_i`. With `cfg_loop`=0 it uses the pins.
- R7: `err_o` is set when a receive sync rise comes fewer than `cfg_per`+1 bit clocks after the previous rise. A rise exactly one period later, or any later, sets nothing.
- R8: `err_o` stays high until `err_clr` is high for a clock. If an error and a clear fall in the same clock, the error wins.
- R9: The word in progress when an early sync arrives is discarded. No `rx_valid` occurs until slot A of the new frame is complete.
- R10: A slot whose `tx_ready` cycle sees `tx_valid` low is sent as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half | input | DIV_W | Reference clocks per half bit clock, minus one |
| cfg_per | input | FRM_W | Frame length in bit clocks, minus one |
| cfg_wid | input | FRM_W | Sync high time in bit clocks, minus one |
| cfg_loop | input | 1 | 1 = receiver fed internally from the transmit side |
| tx_data | input | WORD_W | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this clock |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-clock strobe for a new received word |
| rx_slot | output | 1 | Slot of the received word (0 = A, 1 = B) |
| err_o | output | 1 | Sticky early-sync error |
| err_clr | input | 1 | Clears `err_o` |
| sclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync out |
| sd_o | output | 1 | Serial data out |
| fs_i | input | 1 | Frame sync in, used when not in loopback |
| sd_i | input | 1 | Serial data in, used when not in loopback |

## Verification
The hardest state to reach is an early sync. With loopback on, or with the sync pin fed straight from `fs_o`, the receiver only ever sees correctly spaced syncs. The bench therefore runs with loopback off, drives `fs_i` from `fs_o`, and ORs in a one-bit high pulse partway through slot B. That pulse is followed by the true frame start, which is itself early relative to the injected rise. The bench checks the sticky flag, the missing strobes up to the next slot A, and recovery after the flag is cleared.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic {SLOT_A = 1'b0, SLOT_B = 1'b1} slot_e;
endpackage

// File: rtl/sap_clkgen.sv
module sap_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_half,
  output logic             sclk,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [DIV_W-1:0] dcnt;
  logic             sclk_q;
  logic             wrap;

  assign wrap    = (dcnt >= cfg_half);
  assign rise_tk = wrap & ~sclk_q;
  assign fall_tk = wrap & sclk_q;
  assign sclk    = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt   <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      dcnt   <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      dcnt <= dcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/sap_framer.sv
module sap_framer #(
  parameter int FRM_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_tk,
  input  logic [FRM_W-1:0]  cfg_per,
  input  logic [FRM_W-1:0]  cfg_wid,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              fs,
  output logic              sd
);
  logic [FRM_W-1:0]  bcnt, bnxt;
  logic              started, run_nxt, load, fs_q;
  logic [WORD_W-1:0] sh;

  always_comb begin
    bnxt    = (bcnt >= cfg_per) ? '0 : bcnt + FRM_W'(1);
    run_nxt = started | (bcnt >= cfg_per);
    load    = fall_tk & started &
              ((bnxt == FRM_W'(1)) | (bnxt == FRM_W'(cfg_wid + FRM_W'(2))));
  end

  assign tx_ready = load;
  assign fs       = fs_q;
  assign sd       = sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt    <= '0;
      started <= 1'b0;
      fs_q    <= 1'b0;
      sh      <= '0;
    end else if (fall_tk) begin
      bcnt    <= bnxt;
      started <= run_nxt;
      fs_q    <= run_nxt && (bnxt <= cfg_wid);
      if (load) sh <= tx_valid ? tx_data : '0;
      else      sh <= {sh[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sap_receiver.sv
module sap_receiver
  import sap_pkg::*;
#(
  parameter int FRM_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_tk,
  input  logic [FRM_W-1:0]  cfg_per,
  input  logic              fs_in,
  input  logic              sd_in,
  input  logic              err_clr,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_slot,
  output logic              err
);
  localparam int RW = $clog2(WORD_W + 1);

  logic              fs_q, synced;
  logic [FRM_W-1:0]  rcnt;
  logic [RW-1:0]     rem;
  logic [WORD_W-1:0] sh, sh_n;
  slot_e             slot_q;
  logic              s_rise, s_fall, early, done;

  always_comb begin
    s_rise = fs_in & ~fs_q;
    s_fall = ~fs_in & fs_q;
    early  = s_rise & synced & (rcnt < cfg_per);
    done   = (rem == RW'(1)) & ~early;
    sh_n   = {sh[WORD_W-2:0], sd_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      synced   <= 1'b0;
      rcnt     <= '0;
      rem      <= '0;
      sh       <= '0;
      slot_q   <= SLOT_A;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_slot  <= 1'b0;
      err      <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (err_clr) err <= 1'b0;
      if (rise_tk) begin
        fs_q <= fs_in;
        if (early) err <= 1'b1;
        if (s_rise) begin
          rcnt   <= '0;
          synced <= 1'b1;
        end else if (rcnt != '1) begin
          rcnt <= rcnt + FRM_W'(1);
        end
        if (rem != '0) sh <= sh_n;
        if (done) begin
          rx_data  <= sh_n;
          rx_valid <= 1'b1;
          rx_slot  <= slot_q;
        end
        if (s_rise) begin
          rem    <= RW'(WORD_W);
          slot_q <= SLOT_A;
        end else if (s_fall && synced) begin
          rem    <= RW'(WORD_W);
          slot_q <= SLOT_B;
        end else if (rem != '0) begin
          rem <= rem - RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sap_master.sv
module sap_master #(
  parameter int DIV_W  = 8,
  parameter int FRM_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [FRM_W-1:0]  cfg_per,
  input  logic [FRM_W-1:0]  cfg_wid,
  input  logic              cfg_loop,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_slot,
  output logic              err_o,
  input  logic              err_clr,
  output logic              sclk_o,
  output logic              fs_o,
  output logic              sd_o,
  input  logic              fs_i,
  input  logic              sd_i
);
  logic rise_tk, fall_tk;
  logic rx_fs, rx_sd;

  sap_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_half(cfg_half),
    .sclk    (sclk_o),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  sap_framer #(.FRM_W(FRM_W), .WORD_W(WORD_W)) i_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_tk (fall_tk),
    .cfg_per (cfg_per),
    .cfg_wid (cfg_wid),
    .tx_data (tx_data),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .fs      (fs_o),
    .sd      (sd_o)
  );

  assign rx_fs = cfg_loop ? fs_o : fs_i;
  assign rx_sd = cfg_loop ? sd_o : sd_i;

  sap_receiver #(.FRM_W(FRM_W), .WORD_W(WORD_W)) i_receiver (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_tk (rise_tk),
    .cfg_per (cfg_per),
    .fs_in   (rx_fs),
    .sd_in   (rx_sd),
    .err_clr (err_clr),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .rx_slot (rx_slot),
    .err     (err_o)
  );
endmodule

// File: rtl/sap_master_chk.sv
module sap_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_half,
  input logic             sclk_o,
  input logic             fs_o,
  input logic             sd_o,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             err_o,
  input logic             err_clr
);
  logic           sclk_d;
  logic [DIV_W:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      run    <= '0;
    end else begin
      sclk_d <= sclk_o;
      run    <= (sclk_o != sclk_d) ? (DIV_W+1)'(1) : run + (DIV_W+1)'(1);
    end
  end

  AST_SCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o != sclk_d) |-> (run == {1'b0, cfg_half} + (DIV_W+1)'(1))); // R1
  AST_FS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_o) |-> $fell(sclk_o)); // R4
  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_o) |-> $fell(sclk_o)); // R4
  AST_READY_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> $fell(sclk_o)); // R4
  AST_RX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !err_clr) |=> err_o); // R8
endmodule

bind sap_master sap_master_chk #(.DIV_W(DIV_W)) i_sap_master_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_half(cfg_half),
  .sclk_o  (sclk_o),
  .fs_o    (fs_o),
  .sd_o    (sd_o),
  .tx_ready(tx_ready),
  .rx_valid(rx_valid),
  .err_o   (err_o),
  .err_clr (err_clr)
);

// File: tb/test_sap_master.sv
module test_sap_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8, FRM_W = 8, WORD_W = 16;
  localparam int FRAME_CLK = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_half = 8'd3;
  logic [FRM_W-1:0] cfg_per = 8'd31, cfg_wid = 8'd15;
  logic cfg_loop = 1'b1;
  logic [WORD_W-1:0] tx_data = 16'h8001;
  logic tx_valid = 1'b1, tx_ready;
  logic [WORD_W-1:0] rx_data;
  logic rx_valid, rx_slot, err_o, err_clr = 1'b0;
  logic sclk_o, fs_o, sd_o, fs_i = 1'b0, sd_i = 1'b0;

  sap_master #(.DIV_W(DIV_W), .FRM_W(FRM_W), .WORD_W(WORD_W)) i_sap_master (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_per(cfg_per), .cfg_wid(cfg_wid),
    .cfg_loop(cfg_loop), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_slot(rx_slot), .err_o(err_o),
    .err_clr(err_clr), .sclk_o(sclk_o), .fs_o(fs_o), .sd_o(sd_o), .fs_i(fs_i), .sd_i(sd_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int lb_cmp = 0, ext_cmp = 0, zero_seen = 0, rxv_cnt = 0;
  bit ext_phase = 0, sb_on = 0, inj = 0, adv = 0, done = 0;
  logic [16:0] q_lb[$], q_pin[$], q_ext[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Scoreboard driver, pin model and monitor, all at the falling clock edge
  logic sclk_last = 1'b0, tx_slot = 1'b0;
  logic p_fs = 1'b0, p_slot = 1'b0, c_fs = 1'b0;
  int p_rem = 0, c_cnt = 0, nz = 0;
  logic [15:0] p_sh = '0, c_sh = '0, c_word = 16'h1357;

  always @(negedge clk) begin
    bit s_rise, s_fall;
    logic [16:0] e;
    s_rise = sclk_o & !sclk_last;
    s_fall = !sclk_o & sclk_last;
    sclk_last = sclk_o;
    nz++;
    if (!rst_n) begin
      tx_slot = 0; p_fs = 0; p_rem = 0; c_fs = 0; c_cnt = 0; adv = 0;
    end else begin
      // transmit driver: expected words in slot order (R4, R10)
      if (adv) begin tx_data = lfsr(tx_data); adv = 0; end
      if (tx_ready) begin
        e = {tx_slot, tx_valid ? tx_data : 16'h0};
        if (!ext_phase) begin q_lb.push_back(e); q_pin.push_back(e); end
        tx_slot = ~tx_slot;
        if (tx_valid) adv = 1;
      end
      // pin model of the outgoing stream, sampled as sclk rises (R4)
      if (!ext_phase && s_rise) begin
        if (p_rem > 0) p_sh = {p_sh[14:0], sd_o};
        if (p_rem == 1) begin
          if (q_pin.size() == 0) chk(0, "R4 pin word without expectation", {15'd0, p_slot, p_sh}, 0);
          else begin
            e = q_pin.pop_front();
            chk({p_slot, p_sh} == e, "R4 serial word on sd_o", {15'd0, p_slot, p_sh}, {15'd0, e});
            if (e[15:0] == 16'h0 && p_sh == 16'h0) zero_seen++;
          end
        end
        if (fs_o && !p_fs) begin p_rem = 16; p_slot = 0; end
        else if (!fs_o && p_fs) begin p_rem = 16; p_slot = 1; end
        else if (p_rem > 0) p_rem--;
        p_fs = fs_o;
      end
      // receive-side pins
      if (!ext_phase) begin
        fs_i = nz[3] ^ nz[5];
        sd_i = 1'b1;
      end else begin
        fs_i = fs_o | inj;
        if (s_fall) begin
          if (c_cnt > 0) begin sd_i = c_sh[15]; c_sh = {c_sh[14:0], 1'b0}; c_cnt--; end
          else sd_i = 1'b0;
          if (fs_o != c_fs) begin
            c_fs = fs_o;
            c_sh = c_word; c_cnt = 16;
            if (sb_on) q_ext.push_back({!fs_o, c_word});
            c_word = lfsr(c_word);
          end
        end
      end
      // monitor
      if (rx_valid) begin
        rxv_cnt++;
        if (!ext_phase) begin
          if (q_lb.size() == 0) chk(0, "R6 loopback word without expectation", {15'd0, rx_slot, rx_data}, 0);
          else begin
            e = q_lb.pop_front();
            chk({rx_slot, rx_data} == e, "R6 loopback word", {15'd0, rx_slot, rx_data}, {15'd0, e});
            lb_cmp++;
          end
        end else if (sb_on) begin
          if (q_ext.size() == 0) chk(0, "R5 received word without expectation", {15'd0, rx_slot, rx_data}, 0);
          else begin
            e = q_ext.pop_front();
            chk({rx_slot, rx_data} == e, "R5 received word from pins", {15'd0, rx_slot, rx_data}, {15'd0, e});
            ext_cmp++;
          end
        end
      end
    end
  end

  task automatic set_valid(input bit v);
    do begin @(posedge clk); #1; end while (tx_ready);
    tx_valid = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    time t0, t1, t2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3 reset state
    chk({sclk_o, fs_o, sd_o, tx_ready, rx_valid, err_o} == 6'b0, "R3 reset outputs",
        {26'd0, sclk_o, fs_o, sd_o, tx_ready, rx_valid, err_o}, 0);
    rst_n = 1'b1;
    c = 0;
    do begin @(negedge clk); c++; end while (!fs_o && c < 1000);
    chk(c == FRAME_CLK, "R3 first sync after one frame", c, FRAME_CLK);
    // R1 bit clock period
    @(posedge sclk_o); t0 = $time;
    @(posedge sclk_o); t1 = $time;
    chk(t1 - t0 == 8 * CLK_PERIOD, "R1 bit clock period", 32'(t1 - t0), 8 * CLK_PERIOD);
    // R2 frame period and sync width
    @(posedge fs_o); t0 = $time;
    @(negedge fs_o); t1 = $time;
    @(posedge fs_o); t2 = $time;
    chk(t1 - t0 == 128 * CLK_PERIOD, "R2 sync high time", 32'(t1 - t0), 128 * CLK_PERIOD);
    chk(t2 - t0 == 256 * CLK_PERIOD, "R2 frame period", 32'(t2 - t0), 256 * CLK_PERIOD);
    repeat (5 * FRAME_CLK) @(posedge clk);
    // R10 underrun gives zero words
    set_valid(0);
    repeat (2 * FRAME_CLK) @(posedge clk);
    set_valid(1);
    repeat (3 * FRAME_CLK) @(posedge clk);
    @(negedge clk);
    chk(zero_seen >= 2, "R10 zero words on underrun", zero_seen, 2);
    chk(lb_cmp >= 16, "R6 loopback words delivered", lb_cmp, 16);
    chk(err_o == 1'b0, "R6 pin sync noise ignored in loopback", {31'd0, err_o}, 0);

    // external phase
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    q_lb.delete(); q_pin.delete(); q_ext.delete();
    ext_phase = 1; cfg_loop = 1'b0; sb_on = 1;
    rst_n = 1'b1;
    repeat (8 * FRAME_CLK) @(posedge clk);
    @(negedge clk);
    chk(ext_cmp >= 12, "R5 words received from pins", ext_cmp, 12);
    chk(err_o == 1'b0, "R7 no error at exact period", {31'd0, err_o}, 0);

    // early sync injection
    sb_on = 0;
    q_ext.delete();
    @(negedge fs_o);
    repeat (4) @(negedge sclk_o);
    @(negedge clk);
    c = rxv_cnt;
    inj = 1;
    @(negedge sclk_o);
    @(negedge clk);
    inj = 0;
    repeat (2) @(negedge clk);
    chk(err_o == 1'b1, "R7 early sync flagged", {31'd0, err_o}, 1);
    @(posedge fs_o);
    repeat (8) @(negedge clk);
    chk(rxv_cnt == c, "R9 interrupted word discarded", rxv_cnt - c, 0);
    repeat (2 * FRAME_CLK) @(posedge clk);
    @(negedge clk);
    chk(err_o == 1'b1, "R8 error held", {31'd0, err_o}, 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_o == 1'b0, "R8 error cleared", {31'd0, err_o}, 0);
    c = rxv_cnt;
    repeat (3 * FRAME_CLK) @(posedge clk);
    @(negedge clk);
    chk(err_o == 1'b0, "R7 no error after resync", {31'd0, err_o}, 0);
    chk(rxv_cnt - c >= 4, "R9 reception resumes", rxv_cnt - c, 4);

    done = 1;
    summary();
    $finish;
  end
endmodule